// File: doc/BRIEF.md
# Audio Sample FIFO with Interrupt Controller

This block is the sample buffer between a consumer digital-audio serial engine and the rest of the chip. A receive engine pushes decoded words into it; a transmit engine pops words out of it. Software reaches the same buffer through a small 32-bit register bus: four word registers and one data address. A control bit hands the buffer either to the register bus or to the streaming path. The line coding and the engines themselves live elsewhere. Here they appear only as four event inputs and a channel tag on pushed words.

Fill level is compared against two programmable thresholds, giving empty, almost-empty, full and almost-full conditions. These conditions are combined with FIFO access errors and the engine events. Each one sets a sticky flag. Software clears a flag by writing zero to it. Each flag has its own enable bit, and a global enable gates the whole set onto a single interrupt line.

Two self-restoring control bits give cheap recovery. One empties the buffer and keeps the thresholds. The other puts the configuration back to its reset values.

Top module: `audfifo_top`

## Requirements
- R1: Out of reset the control register reads 0x00000500, the FIFO-control register reads 0x00200020, the status register shows fill level 0 with empty (bit 24) and almost-empty (bit 25) set, and `irq` is low.
- R2: Registers decode at byte offsets 0x0 (control), 0x4 (interrupt flags), 0x8 (FIFO control), 0xC (status) and 0x100 (data). A read returns its value one clock after `bus_rd`. Any other offset reads zero, and writes to it are ignored.
- R3: Words written to the data port are read back in the same order. Status bits [CNT_W-1:0] hold the current fill level.
- R4: Status bits show the live level conditions: bit 24 when the level is 0, bit 25 when the level is at or below the almost-empty threshold (FIFO-control bits [CNT_W-1:0]), bit 26 when the level equals DEPTH, and bit 27 when the level is at or above the almost-full threshold (FIFO-control bits starting at 16).
- R5: A push into a full buffer is dropped and sets the overrun flag (bit 23). A pop from an empty buffer returns zero and sets the underrun flag (bit 22).
- R6: Writing control with bit 10 at 0 empties the buffer. The thresholds are left unchanged, and bit 10 reads back as 1.
- R7: Writing control with bit 8 at 0 restores control and FIFO-control to their reset values. Flags are left unchanged, and bit 8 reads back as 1.
- R8: Interrupt-register bits 21..30 (parity, underrun, overrun, empty, almost-empty, full, almost-full, sync error, lock, block begin) are sticky. A flag is set on any clock edge where its source is true. Writing 0 to a flag clears it and writing 1 leaves it. When set and clear land on the same edge, the set wins.
- R9: `irq` is high exactly when control bit 31 is 1 and some flag i is set with its enable, control bit 21+i, at 1.
- R10: With control bit 19 at 1, the streaming ports own the buffer: data-port writes are ignored and data-port reads return 0 without popping. With bit 19 at 0, `st_push` and `st_pop` are ignored.
- R11: Status bit 31 holds the `st_left` tag of the last accepted stream push. Status bits 21, 28, 29 and 30 show the engine event inputs live. Status bits 22 and 23 mirror the underrun and overrun flags.
- R12: `st_rdata` shows the oldest word, or zero when the buffer is empty. A stream pop on an empty buffer sets the underrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| st_push | input | 1 | Receive engine pushes a word |
| st_pdata | input | 32 | Word pushed by the receive engine |
| st_left | input | 1 | Pushed word belongs to the left channel |
| st_pop | input | 1 | Transmit engine takes the oldest word |
| st_rdata | output | 32 | Oldest word, zero when empty |
| ev_parity | input | 1 | Parity error from the receive engine |
| ev_sync_err | input | 1 | Synchronisation error |
| ev_lock | input | 1 | Receiver locked to the stream |
| ev_block_begin | input | 1 | Start of a new audio block |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH = 32. With that depth the 0x20 reset thresholds sit exactly at full, and every fill level from 0 to full can be reached in a few dozen cycles. This allows each level to be checked against several threshold pairs, including the extremes 0 and DEPTH and the crossed case where almost-full lies below almost-empty. The same small depth makes the overflow, underflow, flush and stream-ownership cases cheap to reach, together with flag set/clear races.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;
    localparam int NUM_SRC = 10;
    localparam int SRC_LSB = 21;

    typedef enum logic [3:0] {
        SRC_PARITY   = 4'd0,
        SRC_UNDERRUN = 4'd1,
        SRC_OVERRUN  = 4'd2,
        SRC_EMPTY    = 4'd3,
        SRC_AEMPTY   = 4'd4,
        SRC_FULL     = 4'd5,
        SRC_AFULL    = 4'd6,
        SRC_SYNC     = 4'd7,
        SRC_LOCK     = 4'd8,
        SRC_BEGIN    = 4'd9
    } src_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    localparam int OFS_CTRL = 'h000;
    localparam int OFS_FLAG = 'h004;
    localparam int OFS_FCTL = 'h008;
    localparam int OFS_STAT = 'h00C;
    localparam int OFS_DATA = 'h100;

    localparam int B_REGRST = 8;
    localparam int B_FLUSH  = 10;
    localparam int B_STREAM = 19;
    localparam int B_GLOBAL = 31;
    localparam int AF_LSB   = 16;

    localparam logic [31:0] CTRL_DEFAULT = 32'h0000_0500;
endpackage

// File: rtl/audfifo_store.sv
module audfifo_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [DW-1:0]    pdata_i,
    input  logic             pop_i,
    output logic [DW-1:0]    head_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             overrun_o,
    output logic             underrun_o
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             push_ok, pop_ok;

    assign push_ok    = push_i && (cnt_q != CNT_W'(DEPTH));
    assign pop_ok     = pop_i && (cnt_q != '0);
    assign overrun_o  = push_i && !push_ok;
    assign underrun_o = pop_i && !pop_ok;
    assign cnt_o      = cnt_q;
    assign head_o     = (cnt_q != '0) ? mem[rd_q] : '0;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !flush_i) begin
            mem[wr_q] <= pdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (flush_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= step(wr_q);
            if (pop_ok)  rd_q <= step(rd_q);
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !flush_i && cnt_q == CNT_W'(DEPTH)) |=> (cnt_q == CNT_W'(DEPTH)));
    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && cnt_q == '0) |-> (head_o == '0));
    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (cnt_q == '0));
endmodule

// File: rtl/audfifo_levels.sv
module audfifo_levels #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] ae_thr_i,
    input  logic [CNT_W-1:0] af_thr_i,
    output logic             empty_o,
    output logic             aempty_o,
    output logic             full_o,
    output logic             afull_o
);
    always_comb begin
        empty_o  = (cnt_i == '0);
        full_o   = (cnt_i == CNT_W'(DEPTH));
        aempty_o = (cnt_i <= ae_thr_i);
        afull_o  = (cnt_i >= af_thr_i);
    end

    always_comb begin
        if (empty_o && full_o) begin
            p_levels_excl_r4: assert (1'b0) else $error("empty and full together");
        end
    end
endmodule

// File: rtl/audfifo_irq.sv
module audfifo_irq
    import audfifo_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    input  src_vec_t enable_i,
    input  logic     global_i,
    output src_vec_t flags_o,
    output logic     irq_o
);
    src_vec_t flags_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                flags_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
                flags_q[i] <= 1'b0;
            end
        end

        p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !clr_i[i]) |=> flags_q[i]);
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_q[i]);
        p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flags_q[i]);
    end

    assign flags_o = flags_q;
    assign irq_o   = global_i && |(flags_q & enable_i);
endmodule

// File: rtl/audfifo_top.sv
module audfifo_top
    import audfifo_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int ADDR_W   = 9,
    parameter int AE_RESET = 32,
    parameter int AF_RESET = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              st_push,
    input  logic [31:0]       st_pdata,
    input  logic              st_left,
    input  logic              st_pop,
    output logic [31:0]       st_rdata,
    input  logic              ev_parity,
    input  logic              ev_sync_err,
    input  logic              ev_lock,
    input  logic              ev_block_begin,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PAD_W = 16 - CNT_W;

    logic [31:0]      ctrl_q;
    logic [CNT_W-1:0] ae_q, af_q;
    logic             last_left_q;

    logic sel_ctrl, sel_flag, sel_fctl, sel_stat, sel_data;
    logic stream_mode, regrst, flush;
    logic fifo_push, fifo_pop, ovr, udr;
    logic [31:0] fifo_pdata, head;
    logic [CNT_W-1:0] cnt;
    logic lv_empty, lv_aempty, lv_full, lv_afull;
    src_vec_t src_set, flag_clr, flags;
    logic [31:0] stat_w, rd_mux;

    assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_flag = (bus_addr == ADDR_W'(OFS_FLAG));
    assign sel_fctl = (bus_addr == ADDR_W'(OFS_FCTL));
    assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
    assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));

    assign stream_mode = ctrl_q[B_STREAM];
    assign regrst      = bus_wr && sel_ctrl && !bus_wdata[B_REGRST];
    assign flush       = bus_wr && sel_ctrl && !bus_wdata[B_FLUSH];

    // buffer ownership
    always_comb begin
        if (stream_mode) begin
            fifo_push  = st_push;
            fifo_pdata = st_pdata;
            fifo_pop   = st_pop;
        end else begin
            fifo_push  = bus_wr && sel_data;
            fifo_pdata = bus_wdata;
            fifo_pop   = bus_rd && sel_data;
        end
    end

    audfifo_store #(.DEPTH(DEPTH), .DW(32), .CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush),
        .push_i     (fifo_push),
        .pdata_i    (fifo_pdata),
        .pop_i      (fifo_pop),
        .head_o     (head),
        .cnt_o      (cnt),
        .overrun_o  (ovr),
        .underrun_o (udr)
    );

    audfifo_levels #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_levels (
        .cnt_i    (cnt),
        .ae_thr_i (ae_q),
        .af_thr_i (af_q),
        .empty_o  (lv_empty),
        .aempty_o (lv_aempty),
        .full_o   (lv_full),
        .afull_o  (lv_afull)
    );

    always_comb begin
        src_set = '0;
        src_set[int'(SRC_PARITY)]   = ev_parity;
        src_set[int'(SRC_UNDERRUN)] = udr;
        src_set[int'(SRC_OVERRUN)]  = ovr;
        src_set[int'(SRC_EMPTY)]    = lv_empty;
        src_set[int'(SRC_AEMPTY)]   = lv_aempty;
        src_set[int'(SRC_FULL)]     = lv_full;
        src_set[int'(SRC_AFULL)]    = lv_afull;
        src_set[int'(SRC_SYNC)]     = ev_sync_err;
        src_set[int'(SRC_LOCK)]     = ev_lock;
        src_set[int'(SRC_BEGIN)]    = ev_block_begin;
    end

    assign flag_clr = (bus_wr && sel_flag) ? ~bus_wdata[SRC_LSB +: NUM_SRC] : '0;

    audfifo_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (src_set),
        .clr_i    (flag_clr),
        .enable_i (ctrl_q[SRC_LSB +: NUM_SRC]),
        .global_i (ctrl_q[B_GLOBAL]),
        .flags_o  (flags),
        .irq_o    (irq)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_DEFAULT;
            ae_q   <= CNT_W'(AE_RESET);
            af_q   <= CNT_W'(AF_RESET);
        end else if (regrst) begin
            ctrl_q <= CTRL_DEFAULT;
            ae_q   <= CNT_W'(AE_RESET);
            af_q   <= CNT_W'(AF_RESET);
        end else begin
            if (bus_wr && sel_ctrl) begin
                ctrl_q <= bus_wdata | (32'd1 << B_REGRST) | (32'd1 << B_FLUSH);
            end
            if (bus_wr && sel_fctl) begin
                ae_q <= bus_wdata[CNT_W-1:0];
                af_q <= bus_wdata[AF_LSB +: CNT_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_left_q <= 1'b0;
        end else if (stream_mode && st_push && !lv_full) begin
            last_left_q <= st_left;
        end
    end

    assign st_rdata = stream_mode ? head : '0;

    always_comb begin
        stat_w = '0;
        stat_w[CNT_W-1:0] = cnt;
        stat_w[SRC_LSB + int'(SRC_PARITY)]   = ev_parity;
        stat_w[SRC_LSB + int'(SRC_UNDERRUN)] = flags[int'(SRC_UNDERRUN)];
        stat_w[SRC_LSB + int'(SRC_OVERRUN)]  = flags[int'(SRC_OVERRUN)];
        stat_w[SRC_LSB + int'(SRC_EMPTY)]    = lv_empty;
        stat_w[SRC_LSB + int'(SRC_AEMPTY)]   = lv_aempty;
        stat_w[SRC_LSB + int'(SRC_FULL)]     = lv_full;
        stat_w[SRC_LSB + int'(SRC_AFULL)]    = lv_afull;
        stat_w[SRC_LSB + int'(SRC_SYNC)]     = ev_sync_err;
        stat_w[SRC_LSB + int'(SRC_LOCK)]     = ev_lock;
        stat_w[SRC_LSB + int'(SRC_BEGIN)]    = ev_block_begin;
        stat_w[31] = last_left_q;
    end

    always_comb begin
        rd_mux = '0;
        if (sel_ctrl)      rd_mux = ctrl_q;
        else if (sel_flag) rd_mux = {1'b0, flags, 21'd0};
        else if (sel_fctl) rd_mux = {{PAD_W{1'b0}}, af_q, {PAD_W{1'b0}}, ae_q};
        else if (sel_stat) rd_mux = stat_w;
        else if (sel_data) rd_mux = stream_mode ? 32'd0 : head;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    p_regrst_fctl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        regrst |=> (ae_q == CNT_W'(AE_RESET) && af_q == CNT_W'(AF_RESET)));
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[B_GLOBAL] |-> !irq);
    p_bus_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_mode && bus_wr && sel_data && !st_push && !st_pop) |=> (cnt == $past(cnt)));
    p_stream_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stream_mode && !bus_wr && !bus_rd && (st_push || st_pop)) |=> (cnt == $past(cnt)));
endmodule

// File: tb/tb_audfifo_top.sv
`timescale 1ns/1ps
module tb_audfifo_top;
    localparam int DEPTH = 32;
    localparam int LVL_MASK = 32'h0000_003F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 0, bus_rd = 0;
    logic [8:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic st_push = 0, st_left = 0, st_pop = 0;
    logic [31:0] st_pdata = '0, st_rdata;
    logic ev_parity = 0, ev_sync_err = 0, ev_lock = 0, ev_block_begin = 0;
    logic irq;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    audfifo_top #(.DEPTH(DEPTH), .ADDR_W(9), .AE_RESET(32), .AF_RESET(32)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .st_push(st_push), .st_pdata(st_pdata), .st_left(st_left),
        .st_pop(st_pop), .st_rdata(st_rdata), .ev_parity(ev_parity),
        .ev_sync_err(ev_sync_err), .ev_lock(ev_lock),
        .ev_block_begin(ev_block_begin), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = 9'(a); bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = 9'(a);
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic spush(input logic [31:0] d, input logic left);
        @(negedge clk); st_push = 1; st_pdata = d; st_left = left;
        @(negedge clk); st_push = 0;
    endtask

    task automatic spop();
        @(negedge clk); st_pop = 1;
        @(negedge clk); st_pop = 0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2, exp;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd('h0, v);   chk("R1 ctrl", v, 32'h0000_0500);
        rd('h8, v);   chk("R1 fctl", v, 32'h0020_0020);
        rd('hC, v);   chk("R1 status", v, 32'h0300_0000);
        rd('h4, v);   chk("R8 empty flags after reset", v, 32'h0300_0000);

        // R2 unmapped
        rd('h10, v);  chk("R2 unmapped 0x10", v, 32'd0);
        rd('h104, v); chk("R2 unmapped 0x104", v, 32'd0);

        // R4 sweep over threshold pairs and every fill level
        for (int t = 0; t < 4; t++) begin
            int ae, af;
            ae = (t == 0) ? 0 : (t == 1) ? 5 : (t == 2) ? 16 : 31;
            af = (t == 0) ? 32 : (t == 1) ? 20 : (t == 2) ? 16 : 1;
            wr('h0, 32'h0000_0100);
            wr('h8, (af << 16) | ae);
            for (int lvl = 0; lvl <= DEPTH; lvl++) begin
                rd('hC, v);
                exp = lvl;
                if (lvl == 0)     exp |= 32'h0100_0000;
                if (lvl <= ae)    exp |= 32'h0200_0000;
                if (lvl == DEPTH) exp |= 32'h0400_0000;
                if (lvl >= af)    exp |= 32'h0800_0000;
                chk("R4 level conditions", v & 32'h0F00_003F, exp);
                if (lvl < DEPTH) wr('h100, 32'h1000 + lvl);
            end
        end

        // R3 / R5 order, overflow, underflow
        wr('h8, 32'h0020_0020);
        wr('h0, 32'h0000_0100);
        wr('h4, 32'h0);
        for (int k = 0; k < DEPTH; k++) wr('h100, 32'hA500_0000 + k * 37);
        wr('h100, 32'hDEAD_BEEF);
        rd('hC, v);  chk("R5 level after overflow", v & LVL_MASK, DEPTH);
        rd('h4, v);  chk("R5 overrun flag", v & 32'h0080_0000, 32'h0080_0000);
        rd('hC, v);  chk("R11 status mirrors overrun", v & 32'h00C0_0000, 32'h0080_0000);
        for (int k = 0; k < DEPTH; k++) begin
            rd('h100, v);
            chk("R3 order", v, 32'hA500_0000 + k * 37);
        end
        rd('h100, v); chk("R5 empty read zero", v, 32'd0);
        rd('h4, v);   chk("R5 underrun flag", v & 32'h0040_0000, 32'h0040_0000);

        // R8 clear by zero, set wins
        wr('h4, 32'h0);
        rd('h4, v);  chk("R8 clear leaves live empty flags", v, 32'h0300_0000);
        @(negedge clk); ev_parity = 1;
        @(negedge clk); ev_parity = 0;
        wr('h4, 32'hFFFF_FFFF);
        rd('h4, v);  chk("R8 write one keeps", v, 32'h0320_0000);
        wr('h4, 32'h0);
        rd('h4, v);  chk("R8 write zero clears", v, 32'h0300_0000);
        @(negedge clk); ev_parity = 1; bus_wr = 1; bus_addr = 9'h4; bus_wdata = 32'h0;
        @(negedge clk); ev_parity = 0; bus_wr = 0;
        rd('h4, v);  chk("R8 set wins over clear", v & 32'h0020_0000, 32'h0020_0000);
        wr('h4, 32'h0);

        // R9 interrupt gating
        wr('h0, 32'h8020_0500);
        @(negedge clk); chk("R9 enabled source idle", {31'd0, irq}, 32'd0);
        @(negedge clk); ev_parity = 1;
        @(negedge clk); ev_parity = 0;
        chk("R9 parity raises irq", {31'd0, irq}, 32'd1);
        wr('h0, 32'h0020_0500);
        @(negedge clk); chk("R9 global off", {31'd0, irq}, 32'd0);
        wr('h0, 32'h8100_0500);
        @(negedge clk); chk("R9 empty enabled", {31'd0, irq}, 32'd1);
        wr('h0, 32'h8000_0500);
        @(negedge clk); chk("R9 all masked", {31'd0, irq}, 32'd0);

        // R6 flush keeps thresholds
        wr('h0, 32'h0000_0500);
        wr('h8, 32'h0011_0004);
        for (int k = 0; k < 5; k++) wr('h100, k);
        rd('hC, v);  chk("R6 level before flush", v & LVL_MASK, 5);
        wr('h0, 32'h0000_0100);
        rd('hC, v);  chk("R6 flushed level", v & LVL_MASK, 0);
        rd('h8, v);  chk("R6 thresholds kept", v, 32'h0011_0004);
        rd('h0, v);  chk("R6 flush bit restores", v, 32'h0000_0500);

        // R7 register reset
        wr('h8, 32'h0007_0003);
        wr('h0, 32'hFFFF_FFFF);
        rd('h0, v);  chk("R7 ctrl write all", v, 32'hFFFF_FFFF);
        wr('h0, 32'h0000_FFFF);
        rd('h4, v2);
        wr('h0, 32'h0000_0000);
        rd('h0, v);  chk("R7 ctrl default", v, 32'h0000_0500);
        rd('h8, v);  chk("R7 fctl default", v, 32'h0020_0020);
        rd('h4, v);  chk("R7 flags unchanged", v, v2);
        chk("R7 irq low after reset", {31'd0, irq}, 32'd0);

        // R10 / R11 / R12 stream path
        wr('h4, 32'h0);
        wr('h0, 32'h0008_0500);
        chk("R12 empty st_rdata", st_rdata, 32'd0);
        spush(32'h0000_1111, 1'b1);
        chk("R12 head word", st_rdata, 32'h0000_1111);
        spush(32'h0000_2222, 1'b0);
        rd('hC, v);  chk("R11 last right", v & 32'h8000_003F, 32'd2);
        wr('h100, 32'h5555_5555);
        rd('hC, v);  chk("R10 bus write ignored", v & LVL_MASK, 2);
        rd('h100, v); chk("R10 bus read zero", v, 32'd0);
        rd('hC, v);  chk("R10 bus read no pop", v & LVL_MASK, 2);
        spop();
        chk("R12 next head", st_rdata, 32'h0000_2222);
        spush(32'h0000_3333, 1'b1);
        rd('hC, v);  chk("R11 last left", v & 32'h8000_003F, 32'h8000_0002);
        spop(); spop();
        chk("R12 drained", st_rdata, 32'd0);
        wr('h4, 32'h0);
        spop();
        rd('h4, v);  chk("R12 stream underrun", v & 32'h0040_0000, 32'h0040_0000);
        wr('h0, 32'h0000_0500);
        spush(32'h0000_4444, 1'b0);
        rd('hC, v);  chk("R10 stream ignored in bus mode", v & LVL_MASK, 0);

        // R11 live event status
        @(negedge clk); ev_lock = 1; ev_sync_err = 1;
        rd('hC, v);  chk("R11 live lock and sync", v & 32'h3000_0000, 32'h3000_0000);
        @(negedge clk); ev_lock = 0; ev_sync_err = 0;
        rd('hC, v);  chk("R11 live events cleared", v & 32'h3000_0000, 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule